// File: doc/BRIEF.md
# Mode-Gated Event Interrupt Collector

This block watches a set of level signals and gathers every change on them into one shared, active-low interrupt line. The watched levels come in three groups: slow-switch status bits, composite video input presence bits and composite video output load presence bits. A rising or falling edge on any bit sets a sticky flag for that bit. The flags form two status words that the register interface presents to the host. The switch flags sit in the first word. The video input and output load flags sit in the second.

Which groups may raise the line depends on a 2-bit operating mode. The whole function is gated by an enable bit. The line is modelled as an open-drain pin: an output enable that pulls the wire low, plus the wire value that an external pull-up would give. The host clears the interrupt by reading both status words. The register interface reports each read as a one-cycle strobe. Reading a word also clears the flags it holds.

Top module: `irq_aggr`

## Requirements
- R1: After reset, irq_oe_o is 0, irq_n_o is 1, and both status words read as zero.
- R2: When a slow-switch bit is sampled at a value that differs from its value at the previous clock edge, status A bit i (i = switch index) is 1 after that edge. This holds in every mode and with the enable at either value.
- R3: A change on video input bit j sets status B bit j. A change on output load bit k sets status B bit NVIN+k. Each is set at the same edge, in every mode and with the enable at either value. Unused upper bits of both words read 0.
- R4: In mode 1 or mode 2 with irq_en_i=1, a change on any source makes irq_oe_o=1 and irq_n_o=0 from the following edge.
- R5: In mode 3, only slow-switch changes assert the line. Video input and load changes still set their flags.
- R6: In mode 0, no source change asserts the line.
- R7: With irq_en_i=0, irq_oe_o is 0. Source changes that happen while the enable is 0 do not assert the line once the enable is set. A pending interrupt stays pending while the enable is 0 and drives the line again when the enable returns to 1.
- R8: A strobe on rd_a_i clears status A, and a strobe on rd_b_i clears status B, at the edge that ends the strobe. A flag whose source changes in that same cycle stays set. The word presented during the strobe cycle holds the flags before the clear.
- R9: A pending interrupt is released at the edge where the second of the two status reads completes. This is true in either order, and also when both strobes come in one cycle. A read of only one word does not release it.
- R10: An enabled event that arrives before both reads have completed discards the reads already made. Both words must be read again afterwards before the line is released.
- R11: The first clock edge after reset only captures the source levels. A source that is already high out of reset sets no flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode: 0 off, 1 and 2 all sources, 3 switch only |
| irq_en_i | input | 1 | Interrupt function enable |
| sw_i | input | NSW | Slow-switch status levels |
| vin_i | input | NVIN | Video input present levels |
| vload_i | input | NVOUT | Video output load present levels |
| rd_a_i | input | 1 | One-cycle strobe: host read status A |
| rd_b_i | input | 1 | One-cycle strobe: host read status B |
| stat_a_o | output | REG_W | Status A: sticky switch change flags |
| stat_b_o | output | REG_W | Status B: sticky video input and load change flags |
| irq_oe_o | output | 1 | Open-drain pull-down enable for the interrupt pin |
| irq_n_o | output | 1 | Resulting pin level with pull-up, active low |

## Verification
The assertions assume that the source levels, the mode, the enable and both read strobes are synchronous to clk_i and stable around each rising edge. They also assume each strobe marks exactly one host read. The bench changes every input only at the falling edge and drives each strobe high for a single cycle. Clearing and event cases are built by placing a source toggle and a strobe in the same falling-edge slot, or in adjacent slots.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_FULL_A = 2'd1,
    MODE_FULL_B = 2'd2,
    MODE_SW_ONLY = 2'd3
  } mode_e;

  function automatic logic sw_allowed(mode_e m);
    return m != MODE_OFF;
  endfunction

  function automatic logic video_allowed(mode_e m);
    return (m == MODE_FULL_A) || (m == MODE_FULL_B);
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= lvl_i;
      primed_q <= 1'b1;
    end
  end

  // first edge after reset only captures levels
  assign chg_o = primed_q ? (lvl_i ^ prev_q) : '0;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (clr_i ? '0 : flag_q);
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/irq_clr_track.sv
module irq_clr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic rd_a_i,
  input  logic rd_b_i,
  output logic pend_o
);
  logic pend_q, seen_a_q, seen_b_q;
  logic seen_a_d, seen_b_d, both_seen;

  assign seen_a_d  = seen_a_q | rd_a_i;
  assign seen_b_d  = seen_b_q | rd_b_i;
  assign both_seen = seen_a_d & seen_b_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (ev_i) begin
      pend_q   <= 1'b1;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (both_seen) begin
      pend_q   <= 1'b0;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= seen_a_d;
      seen_b_q <= seen_b_d;
    end
  end

  assign pend_o = pend_q;

  p_event_restarts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> (pend_q && !seen_a_q && !seen_b_q));

  p_release_after_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && seen_a_q && rd_b_i && !ev_i) |=> !pend_q);

  p_single_read_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !seen_a_q && !seen_b_q && rd_a_i && !rd_b_i) |=> pend_q);
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NSW   = 2,
  parameter int unsigned NVIN  = 2,
  parameter int unsigned NVOUT = 2,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             irq_en_i,
  input  logic [NSW-1:0]   sw_i,
  input  logic [NVIN-1:0]  vin_i,
  input  logic [NVOUT-1:0] vload_i,
  input  logic             rd_a_i,
  input  logic             rd_b_i,
  output logic [REG_W-1:0] stat_a_o,
  output logic [REG_W-1:0] stat_b_o,
  output logic             irq_oe_o,
  output logic             irq_n_o
);
  localparam int unsigned NVID = NVIN + NVOUT;

  logic [NSW-1:0]  sw_chg, sw_flags;
  logic [NVID-1:0] vid_lvl, vid_chg, vid_flags;
  logic            ev_gated, pend;
  mode_e           mode;

  assign mode    = mode_e'(mode_i);
  assign vid_lvl = {vload_i, vin_i};

  irq_edge_det #(.W(NSW)) u_sw_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sw_i), .chg_o(sw_chg));

  irq_edge_det #(.W(NVID)) u_vid_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(vid_lvl), .chg_o(vid_chg));

  irq_flag_bank #(.W(NSW)) u_flags_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sw_chg), .clr_i(rd_a_i), .flags_o(sw_flags));

  irq_flag_bank #(.W(NVID)) u_flags_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(vid_chg), .clr_i(rd_b_i), .flags_o(vid_flags));

  // sources counted toward the line only when enabled and allowed by mode
  assign ev_gated = irq_en_i &
                    ((sw_allowed(mode) & (|sw_chg)) | (video_allowed(mode) & (|vid_chg)));

  irq_clr_track u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_gated),
    .rd_a_i(rd_a_i), .rd_b_i(rd_b_i), .pend_o(pend));

  generate
    if (REG_W > NSW) begin : g_pad_a
      assign stat_a_o = {{(REG_W-NSW){1'b0}}, sw_flags};
    end else begin : g_full_a
      assign stat_a_o = sw_flags;
    end
    if (REG_W > NVID) begin : g_pad_b
      assign stat_b_o = {{(REG_W-NVID){1'b0}}, vid_flags};
    end else begin : g_full_b
      assign stat_b_o = vid_flags;
    end
  endgenerate

  assign irq_oe_o = pend & irq_en_i;
  assign irq_n_o  = ~irq_oe_o;

  initial begin
    a_width_a: assert (NSW <= REG_W);
    a_width_b: assert (NVID <= REG_W);
  end

  p_flag_on_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sw_chg) |=> ((sw_flags & $past(sw_chg)) == $past(sw_chg)));

  p_vid_flag_on_change_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vid_chg) |=> ((vid_flags & $past(vid_chg)) == $past(vid_chg)));

  p_mode3_no_video_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && !pend && sw_chg == '0) |=> !pend);

  p_mode0_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !pend) |=> !pend);

  p_disabled_no_arm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !pend) |=> !pend);
endmodule

// File: tb/irq_aggr_tb_top.sv
module irq_aggr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       en = 1'b0;
  logic [1:0] sw = 2'b00, vin = 2'b00, vload = 2'b00;
  logic       rd_a = 1'b0, rd_b = 1'b0;
  logic [7:0] stat_a, stat_b;
  logic       oe, irq_n;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irq_aggr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .irq_en_i(en),
    .sw_i(sw), .vin_i(vin), .vload_i(vload), .rd_a_i(rd_a), .rd_b_i(rd_b),
    .stat_a_o(stat_a), .stat_b_o(stat_b), .irq_oe_o(oe), .irq_n_o(irq_n));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input logic exp_oe);
    chk(req, {6'b0, oe, irq_n}, {6'b0, exp_oe, ~exp_oe});
  endtask

  task automatic clear_both();
    rd_a = 1'b1; rd_b = 1'b1;
    tick();
    rd_a = 1'b0; rd_b = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    sw = 2'b01; vin = 2'b10;
    rst_n = 1'b0;
    tick(); tick();
    chk_line("R1 reset line", 1'b0);
    chk("R1 reset stat_a", stat_a, 8'h00);
    chk("R1 reset stat_b", stat_b, 8'h00);
    rst_n = 1'b1;
    mode = 2'd1; en = 1'b1;
    tick(); tick(); tick();
    chk("R11 no flag a", stat_a, 8'h00);
    chk("R11 no flag b", stat_b, 8'h00);
    chk_line("R11 no irq", 1'b0);
  endtask

  task automatic t_flags_disabled();
    mode = 2'd0; en = 1'b0;
    sw[1] = ~sw[1];
    tick();
    chk("R2 sw flag", stat_a, 8'h02);
    chk_line("R6 mode0 quiet", 1'b0);
    vin[0] = ~vin[0];
    tick();
    chk("R3 vin flag", stat_b, 8'h01);
    vload[1] = ~vload[1];
    tick();
    chk("R3 load flag", stat_b, 8'h09);
    mode = 2'd1;
    sw[0] = ~sw[0];
    tick();
    chk("R2 flag with en low", stat_a, 8'h03);
    chk_line("R7 released when disabled", 1'b0);
    rd_a = 1'b1;
    #1 chk("R8 read data a", stat_a, 8'h03);
    tick(); rd_a = 1'b0;
    chk("R8 a cleared", stat_a, 8'h00);
    chk("R8 b untouched", stat_b, 8'h09);
    rd_b = 1'b1;
    tick(); rd_b = 1'b0;
    chk("R8 b cleared", stat_b, 8'h00);
    en = 1'b1;
    tick();
    chk_line("R7 no late assert", 1'b0);
  endtask

  task automatic t_full_modes();
    mode = 2'd1; en = 1'b1;
    vin[1] = ~vin[1];
    tick();
    chk_line("R4 mode1 vin event", 1'b1);
    rd_a = 1'b1; tick(); rd_a = 1'b0;
    chk_line("R9 one read holds", 1'b1);
    tick();
    chk_line("R9 still held", 1'b1);
    rd_b = 1'b1; tick(); rd_b = 1'b0;
    chk_line("R9 released after both", 1'b0);
    mode = 2'd2;
    vload[0] = ~vload[0];
    tick();
    chk_line("R4 mode2 load event", 1'b1);
    rd_b = 1'b1; tick(); rd_b = 1'b0;
    chk_line("R9 b first holds", 1'b1);
    rd_a = 1'b1; tick(); rd_a = 1'b0;
    chk_line("R9 b then a releases", 1'b0);
    sw[1] = ~sw[1];
    tick();
    chk_line("R4 mode2 sw event", 1'b1);
    clear_both();
    chk_line("R9 same-cycle reads release", 1'b0);
  endtask

  task automatic t_mode3();
    mode = 2'd3; en = 1'b1;
    vin[0] = ~vin[0];
    tick();
    chk_line("R5 video ignored", 1'b0);
    chk("R5 video flag set", stat_b, 8'h01);
    vload[1] = ~vload[1];
    tick();
    chk_line("R5 load ignored", 1'b0);
    sw[0] = ~sw[0];
    tick();
    chk_line("R5 sw asserts", 1'b1);
    sw[1] = ~sw[1]; rd_a = 1'b1;
    tick(); rd_a = 1'b0;
    chk("R8 flag kept on same-cycle change", stat_a, 8'h02);
    rd_b = 1'b1; tick(); rd_b = 1'b0;
    chk_line("R10 earlier read discarded", 1'b1);
    rd_a = 1'b1; tick(); rd_a = 1'b0;
    chk_line("R10 released after fresh reads", 1'b0);
    chk("R8 a cleared", stat_a, 8'h00);
  endtask

  task automatic t_enable_toggle();
    mode = 2'd1; en = 1'b1;
    sw[0] = ~sw[0];
    tick();
    chk_line("R4 event asserts", 1'b1);
    en = 1'b0;
    tick();
    chk_line("R7 disabled releases", 1'b0);
    en = 1'b1;
    tick();
    chk_line("R7 pending returns", 1'b1);
    clear_both();
    chk_line("R9 cleared", 1'b0);
    mode = 2'd0;
    sw[1] = ~sw[1];
    tick();
    chk_line("R6 mode0 sw ignored", 1'b0);
    chk("R2 mode0 flag", stat_a, 8'h02);
  endtask

  initial begin
    fork
      begin
        tick();
        t_reset();
        t_flags_disabled();
        t_full_modes();
        t_mode3();
        t_enable_toggle();
        done = 1'b1;
      end
      begin
        repeat (5000) @(negedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule